// File: doc/BRIEF.md
# PC-Relative Conditional Jump Unit

This block carries out the jump-format instructions of a 16-bit processor. The sequencer presents one instruction word together with the address of that instruction and the four status flags (zero, carry, negative, overflow), and pulses `issue_i` for one cycle. The unit checks that the word belongs to the jump group and picks one of eight conditions from a 3-bit field. It then computes the address of the next instruction and reports it with a one-cycle `done_o` strobe. Every jump costs the same two cycles, taken or not, and no flag is ever written.

The displacement is a signed 10-bit count of 16-bit words. The unit doubles it and adds it to the address that follows the jump word. The target can therefore lie from 511 words before to 512 words after the jump instruction, and all address arithmetic wraps modulo 2^16. Between strobes the result outputs keep the last completed jump.

Top module: `jump_exec_unit`

## Requirements
- R1: After reset `done_o`, `taken_o` and `next_pc_o` are all zero.
- R2: A word with bits [15:13] = 3'b001, presented with `issue_i` while no jump is in flight, is accepted at that clock edge. `done_o` is then high for exactly one cycle, after the second rising edge counted from the accepting edge. This holds whether or not the jump is taken.
- R3: Bits [12:10] select the condition: 0 taken when Z=0, 1 when Z=1, 2 when C=0, 3 when C=1, 4 when N=1, 5 when N equals V, 6 when N differs from V, 7 always. `taken_o` shows the outcome alongside `done_o`.
- R4: For a taken jump, `next_pc_o` = PC + 2 + 2 × sign-extended bits [9:0], modulo 2^16.
- R5: For a jump not taken, `next_pc_o` = PC + 2, modulo 2^16.
- R6: An offset field of 10'h1FF reaches PC + 1024 bytes (+512 words), and 10'h200 reaches PC − 1022 bytes (−511 words).
- R7: A word whose bits [15:13] differ from 3'b001 is ignored: no `done_o` follows, and the result outputs stay unchanged.
- R8: An `issue_i` seen while a jump is in flight is ignored. It produces no second `done_o` and does not change the result.
- R9: `taken_o` and `next_pc_o` change only in a cycle in which `done_o` is high, and hold their values otherwise.
- R10: The word, PC and flags are sampled at the accepting edge. Changes to them afterwards do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | Instruction word presented this cycle |
| instr_i | input | 16 | Instruction word |
| pc_i | input | 16 | Address of the instruction word |
| flag_z_i | input | 1 | Zero flag |
| flag_c_i | input | 1 | Carry flag |
| flag_n_i | input | 1 | Negative flag |
| flag_v_i | input | 1 | Overflow flag |
| done_o | output | 1 | One-cycle completion strobe |
| taken_o | output | 1 | Condition held for the last completed jump |
| next_pc_o | output | 16 | Address of the next instruction |

## Verification
The bench raises `issue_i` on a falling edge, so the word is accepted at the next rising edge. It samples at each later falling edge. One falling edge later, `done_o` must still be low. Two falling edges later, `done_o`, `taken_o` and `next_pc_o` must carry the result. Three falling edges later, the strobe must be gone and the result must still be held. In the middle cycle the bench can present a changed word, PC and flags with `issue_i` high. The result that follows must still match the values sampled at the accepting edge, and the cycle after it must show no second strobe.

// File: rtl/jmp_pkg.sv
package jmp_pkg;

    typedef enum logic [2:0] {
        CC_ZCLR = 3'd0,
        CC_ZSET = 3'd1,
        CC_CCLR = 3'd2,
        CC_CSET = 3'd3,
        CC_NEG  = 3'd4,
        CC_GE   = 3'd5,
        CC_LT   = 3'd6,
        CC_ALW  = 3'd7
    } cond_e;

endpackage

// File: rtl/jmp_cond_eval.sv
module jmp_cond_eval
    import jmp_pkg::*;
(
    input  cond_e cond_i,
    input  logic  z_i,
    input  logic  c_i,
    input  logic  n_i,
    input  logic  v_i,
    output logic  take_o
);

    always_comb begin
        unique case (cond_i)
            CC_ZCLR: take_o = ~z_i;
            CC_ZSET: take_o = z_i;
            CC_CCLR: take_o = ~c_i;
            CC_CSET: take_o = c_i;
            CC_NEG:  take_o = n_i;
            CC_GE:   take_o = ~(n_i ^ v_i);
            CC_LT:   take_o = n_i ^ v_i;
            default: take_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/jmp_target_calc.sv
module jmp_target_calc #(
    parameter int DATA_W = 16,
    parameter int OFS_W  = 10
) (
    input  logic [DATA_W-1:0] pc_i,
    input  logic [OFS_W-1:0]  ofs_i,
    output logic [DATA_W-1:0] seq_pc_o,
    output logic [DATA_W-1:0] tgt_pc_o
);

    localparam int EXT_W = DATA_W - OFS_W - 1;

    logic [DATA_W-1:0] disp;

    always_comb begin
        // word count to byte count: sign-extend, then shift left by one
        disp     = {{EXT_W{ofs_i[OFS_W-1]}}, ofs_i, 1'b0};
        seq_pc_o = pc_i + DATA_W'(2);
        tgt_pc_o = seq_pc_o + disp;
    end

endmodule

// File: rtl/jump_exec_unit.sv
module jump_exec_unit
    import jmp_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int OFS_W  = 10
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              issue_i,
    input  logic [DATA_W-1:0] instr_i,
    input  logic [DATA_W-1:0] pc_i,
    input  logic              flag_z_i,
    input  logic              flag_c_i,
    input  logic              flag_n_i,
    input  logic              flag_v_i,
    output logic              done_o,
    output logic              taken_o,
    output logic [DATA_W-1:0] next_pc_o
);

    localparam int COND_LSB = OFS_W;
    localparam int COND_MSB = OFS_W + 2;
    localparam int OPC_LSB  = OFS_W + 3;
    localparam int OPC_W    = DATA_W - OPC_LSB;
    localparam logic [OPC_W-1:0] OPC_JUMP = OPC_W'(1);

    typedef struct packed {
        logic              busy;
        logic              pend_take;
        logic [DATA_W-1:0] pend_pc;
        logic              done;
        logic              take;
        logic [DATA_W-1:0] npc;
    } state_t;

    state_t st_d, st_q;

    logic              is_jump;
    logic              cond_take;
    logic [DATA_W-1:0] seq_pc;
    logic [DATA_W-1:0] tgt_pc;

    assign is_jump = (instr_i[DATA_W-1:OPC_LSB] == OPC_JUMP);

    jmp_cond_eval u_cond (
        .cond_i (cond_e'(instr_i[COND_MSB:COND_LSB])),
        .z_i    (flag_z_i),
        .c_i    (flag_c_i),
        .n_i    (flag_n_i),
        .v_i    (flag_v_i),
        .take_o (cond_take)
    );

    jmp_target_calc #(
        .DATA_W (DATA_W),
        .OFS_W  (OFS_W)
    ) u_tgt (
        .pc_i     (pc_i),
        .ofs_i    (instr_i[OFS_W-1:0]),
        .seq_pc_o (seq_pc),
        .tgt_pc_o (tgt_pc)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.busy) begin
            // second cycle: publish the held result
            st_d.busy = 1'b0;
            st_d.done = 1'b1;
            st_d.take = st_q.pend_take;
            st_d.npc  = st_q.pend_pc;
        end else if (issue_i && is_jump) begin
            st_d.busy      = 1'b1;
            st_d.pend_take = cond_take;
            st_d.pend_pc   = cond_take ? tgt_pc : seq_pc;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o    = st_q.done;
    assign taken_o   = st_q.take;
    assign next_pc_o = st_q.npc;

endmodule

// File: rtl/jump_exec_chk.sv
module jump_exec_chk #(
    parameter int DATA_W = 16,
    parameter int OFS_W  = 10
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              issue_i,
    input logic [DATA_W-1:0] instr_i,
    input logic [DATA_W-1:0] pc_i,
    input logic              busy_i,
    input logic              done_i,
    input logic              taken_i,
    input logic [DATA_W-1:0] next_pc_i
);

    localparam int TOP_W = DATA_W - OFS_W;

    // R2: an in-flight jump completes on the following cycle
    assert_busy_done_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_i |=> done_i);

    // R2: the strobe is one cycle wide
    assert_done_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_i |=> !done_i);

    // R9: results hold outside the strobe
    assert_result_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_i |=> ($stable(next_pc_i) && $stable(taken_i)) || done_i);

    // R5: fall-through address is two bytes past the sampled PC
    assert_fallthrough_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_i && !taken_i) |-> next_pc_i == DATA_W'($past(pc_i, 2) + DATA_W'(2)));

    // R3: the unconditional code is always taken, two cycles later
    assert_always_taken_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (issue_i && !busy_i && instr_i[DATA_W-1:OFS_W] == TOP_W'(6'b001111))
        |-> ##2 (done_i && taken_i));

endmodule

bind jump_exec_unit jump_exec_chk #(
    .DATA_W (DATA_W),
    .OFS_W  (OFS_W)
) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .issue_i   (issue_i),
    .instr_i   (instr_i),
    .pc_i      (pc_i),
    .busy_i    (st_q.busy),
    .done_i    (done_o),
    .taken_i   (taken_o),
    .next_pc_i (next_pc_o)
);

// File: tb/jump_exec_unit_tb.sv
`timescale 1ns/1ps
module jump_exec_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [15:0] instr = '0;
    logic [15:0] pc = '0;
    logic [3:0]  flg = '0;   // {z,c,n,v}
    logic        done;
    logic        taken;
    logic [15:0] npc;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    jump_exec_unit u_dut (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .issue_i   (issue),
        .instr_i   (instr),
        .pc_i      (pc),
        .flag_z_i  (flg[3]),
        .flag_c_i  (flg[2]),
        .flag_n_i  (flg[1]),
        .flag_v_i  (flg[0]),
        .done_o    (done),
        .taken_o   (taken),
        .next_pc_o (npc)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit exp_take(input logic [2:0] c, input logic [3:0] f);
        logic z, cy, n, v;
        {z, cy, n, v} = f;
        case (c)
            3'd0: return !z;
            3'd1: return z;
            3'd2: return !cy;
            3'd3: return cy;
            3'd4: return n;
            3'd5: return n == v;
            3'd6: return n != v;
            default: return 1'b1;
        endcase
    endfunction

    task automatic run_jump(input logic [15:0] ins, input logic [15:0] p,
                            input logic [3:0] f, input bit disturb, input string tag);
        bit          tk;
        int          ofs;
        logic [15:0] exp_pc;
        tk     = exp_take(ins[12:10], f);
        ofs    = $signed(ins[9:0]);
        exp_pc = tk ? 16'(int'(p) + 2 + 2 * ofs) : 16'(p + 16'd2);
        @(negedge clk);
        instr = ins; pc = p; flg = f; issue = 1'b1;
        @(negedge clk);
        chk(done == 1'b0, "R2 early strobe", 32'(done), 32'd0);
        if (disturb) begin
            instr = ins ^ 16'h1C00; pc = ~p; flg = ~f; issue = 1'b1;
        end else begin
            issue = 1'b0;
        end
        @(negedge clk);
        issue = 1'b0;
        chk(done == 1'b1, "R2 strobe", 32'(done), 32'd1);
        chk(taken == tk, disturb ? "R3 R10 taken" : "R3 taken", 32'(taken), 32'(tk));
        chk(npc == exp_pc, disturb ? {tag, " R10"} : tag, 32'(npc), 32'(exp_pc));
        @(negedge clk);
        chk(done == 1'b0, "R8 second strobe", 32'(done), 32'd0);
        chk(npc == exp_pc && taken == tk, "R9 hold", 32'(npc), 32'(exp_pc));
    endtask

    task automatic run_other(input logic [15:0] ins);
        logic [15:0] old_pc;
        logic        old_tk;
        old_pc = npc;
        old_tk = taken;
        @(negedge clk);
        instr = ins; pc = 16'h1234; flg = 4'hF; issue = 1'b1;
        @(negedge clk);
        issue = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk(done == 1'b0, "R7 no strobe", 32'(done), 32'd0);
            chk(npc == old_pc && taken == old_tk, "R7 result kept", 32'(npc), 32'(old_pc));
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R1 done", 32'(done), 32'd0);
        chk(taken == 1'b0, "R1 taken", 32'(taken), 32'd0);
        chk(npc == 16'h0000, "R1 next_pc", 32'(npc), 32'd0);
        rst_n = 1'b1;

        // condition sweep: every code against every flag combination
        for (int c = 0; c < 8; c++) begin
            for (int f = 0; f < 16; f++) begin
                logic [15:0] w;
                w = 16'h2000 | 16'(c << 10) | 16'((c * 37 + f * 71) & 10'h3FF);
                run_jump(w, 16'(c * 16'h1111 + f * 6), 4'(f), f[0], "R4 R5 next_pc");
            end
        end

        // offset sweep with the unconditional code, including wrap
        for (int o = 0; o < 1024; o++) begin
            run_jump(16'h3C00 | 16'(o), o[0] ? 16'hFFF8 : 16'h0004, 4'h0, 1'b0, "R4 target");
        end

        // reach limits
        run_jump(16'h3DFF, 16'h8000, 4'h0, 1'b0, "R6 +512 words");
        chk(npc == 16'h8400, "R6 forward limit", 32'(npc), 32'h8400);
        run_jump(16'h3E00, 16'h8000, 4'h0, 1'b0, "R6 -511 words");
        chk(npc == 16'h7C02, "R6 backward limit", 32'(npc), 32'h7C02);
        // not-taken wrap at the top of the address space
        run_jump(16'h2000, 16'hFFFE, 4'h8, 1'b0, "R5 wrap");
        chk(npc == 16'h0000, "R5 wrap value", 32'(npc), 32'h0);

        // words outside the jump group
        run_other(16'h0000);
        run_other(16'h1C00);
        run_other(16'h4000);
        run_other(16'hC3FF);
        run_other(16'hFFFF);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired at %0t", $time);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule